// File: doc/BRIEF.md
# Byte-Addressed Register Bank Slave

This block is a bus slave for a classic (non-pipelined) Wishbone cycle with a 32-bit data path. It holds a small bank of 32-bit read/write registers that sit in a window of `WIN_BYTES` bytes, where `WIN_BYTES` is a power of two. Addresses count bytes in little-endian order. Offset 0x0 is the lowest byte of register 0, and offset 0x4 is the lowest byte of register 1. The slave looks only at the address bits that pick a byte inside its window. It never sees where the window sits in the system map, so every image of the window above it decodes the same way.

An access starts on a rising edge where cycle and strobe are high and no response is pending. On that edge the slave performs the access and raises a registered acknowledge. For a misaligned address it raises an error instead. The response stays high for as long as the master holds the cycle, and it clears on the first edge where the cycle line is low. Writes use the four byte-select lines to update single byte lanes. Only the first `NUM_REGS` word slots of the window hold storage. The remaining slots read as zero and ignore writes.

Top module: `wbreg_slave`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and drives the acknowledge, the error and the read data to zero.
- R2: On an edge where cycle and strobe are high, both responses are low and address bits [1:0] are zero, the access is performed and the acknowledge is high after that edge.
- R3: Once high, the acknowledge or the error stays high while cycle stays high. Each clears after the first edge on which cycle is low.
- R4: While a response is held high, no further access occurs. A change of write data during the hold does not reach the registers.
- R5: A write updates only the byte lanes whose select bit is 1. Select bit n controls data bits [8n+7:8n], and select 0000 leaves the register unchanged.
- R6: A read returns the full 32-bit register at word index address[AW-1:2], where AW = log2(WIN_BYTES). The read data is valid with the acknowledge and holds while it stays high.
- R7: Only address bits [AW-1:0] are decoded, so addresses that differ only above bit AW-1 reach the same register.
- R8: An access whose address bits [1:0] are not zero raises the error instead of the acknowledge and leaves every register unchanged.
- R9: A word slot inside the window at index NUM_REGS or above reads as zero with a normal acknowledge and ignores writes.
- R10: With strobe low, or cycle low, no access occurs and no response is raised.
- R11: The acknowledge and the error are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Valid transfer request |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 32 | Byte address; only the low log2(WIN_BYTES) bits are used |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte-lane enables, bit n for data bits [8n+7:8n] |
| wb_dat_o | output | 32 | Registered read data |
| wb_ack_o | output | 1 | Registered acknowledge, held until cycle falls |
| wb_err_o | output | 1 | Registered error for a misaligned address, held until cycle falls |

## Verification
Every response is due exactly one rising edge after the request is first seen. The bench drives the request on a falling edge and samples five nanoseconds after the next rising edge, so an acknowledge or error that is missing or late is reported against R2 or R8. A scoreboard queue holds the expected response type and read word for each transfer, and a monitor compares them at the first sample where a response appears. The bench then keeps the cycle open for one extra edge and changes the write data to check R3 and R4. It drops the cycle and expects both responses to be low one edge later. Writes that must have no effect are checked by reading the affected words back through the bus.

// File: rtl/wbreg_pkg.sv
package wbreg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef logic [DATA_W-1:0] wb_word_t;
  typedef logic [ADDR_W-1:0] wb_addr_t;
  typedef logic [LANES-1:0]  wb_sel_t;
endpackage

// File: rtl/wbreg_decode.sv
// Splits the in-window offset into alignment, word index and mapped flag.
module wbreg_decode #(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned NUM_REGS  = 6,
  localparam int unsigned AW = $clog2(WIN_BYTES),
  localparam int unsigned IW = AW - 2
) (
  input  logic [AW-1:0] off_i,
  output logic          aligned_o,
  output logic          mapped_o,
  output logic [IW-1:0] idx_o
);
  assign aligned_o = (off_i[1:0] == 2'b00);
  assign idx_o     = off_i[AW-1:2];
  assign mapped_o  = ({1'b0, idx_o} < (IW+1)'(NUM_REGS));
endmodule

// File: rtl/wbreg_bank.sv
// Register storage with per-byte-lane write enables; unbuilt slots read zero.
module wbreg_bank
  import wbreg_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned NUM_REGS  = 6,
  localparam int unsigned AW    = $clog2(WIN_BYTES),
  localparam int unsigned IW    = AW - 2,
  localparam int unsigned WORDS = 1 << IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go_i,
  input  logic [IW-1:0] idx_i,
  input  wb_word_t      wdata_i,
  input  wb_sel_t       sel_i,
  output wb_word_t      rdata_o
);
  wb_word_t word_all [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w < NUM_REGS) begin : g_store
      logic hit;
      assign hit = wr_go_i && (idx_i == IW'(w));
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            byte_q <= '0;
          end else if (hit && sel_i[l]) begin
            byte_q <= wdata_i[8*l +: 8];
          end
        end
        assign word_all[w][8*l +: 8] = byte_q;
      end
    end else begin : g_hole
      assign word_all[w] = '0;
    end
  end

  assign rdata_o = word_all[idx_i];
endmodule

// File: rtl/wbreg_resp.sv
// Handshake: registered ack/err held until cyc falls, registered read data.
module wbreg_resp
  import wbreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cyc_i,
  input  logic     stb_i,
  input  logic     we_i,
  input  logic     aligned_i,
  input  wb_word_t rword_i,
  output logic     start_o,
  output logic     ack_o,
  output logic     err_o,
  output wb_word_t dat_o
);
  logic     ack_q, err_q;
  wb_word_t dat_q;

  assign start_o = cyc_i && stb_i && !ack_q && !err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      dat_q <= '0;
    end else if (!cyc_i) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else if (start_o) begin
      if (aligned_i) begin
        ack_q <= 1'b1;
        if (!we_i) dat_q <= rword_i;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign ack_o = ack_q;
  assign err_o = err_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/wbreg_slave.sv
// Top: byte-addressed register bank behind a classic bus slave port.
module wbreg_slave
  import wbreg_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned NUM_REGS  = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [31:0] wb_adr_i,
  input  logic [31:0] wb_dat_i,
  input  logic [3:0]  wb_sel_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o,
  output logic        wb_err_o
);
  localparam int unsigned AW = $clog2(WIN_BYTES);
  localparam int unsigned IW = AW - 2;

  logic          aligned, mapped, start, wr_go;
  logic [IW-1:0] idx;
  wb_word_t      rword;
  logic          unused_hi;

  // Bits above the window are deliberately ignored (R7).
  assign unused_hi = ^wb_adr_i[ADDR_W-1:AW];

  wbreg_decode #(.WIN_BYTES(WIN_BYTES), .NUM_REGS(NUM_REGS)) u_dec (
    .off_i    (wb_adr_i[AW-1:0]),
    .aligned_o(aligned),
    .mapped_o (mapped),
    .idx_o    (idx)
  );

  assign wr_go = start && wb_we_i && aligned && mapped;

  wbreg_bank #(.WIN_BYTES(WIN_BYTES), .NUM_REGS(NUM_REGS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_go_i(wr_go),
    .idx_i  (idx),
    .wdata_i(wb_dat_i),
    .sel_i  (wb_sel_i),
    .rdata_o(rword)
  );

  wbreg_resp u_resp (
    .clk      (clk),
    .rst      (rst),
    .cyc_i    (wb_cyc_i),
    .stb_i    (wb_stb_i),
    .we_i     (wb_we_i),
    .aligned_i(aligned),
    .rword_i  (rword),
    .start_o  (start),
    .ack_o    (wb_ack_o),
    .err_o    (wb_err_o),
    .dat_o    (wb_dat_o)
  );
endmodule

// File: rtl/wbreg_slave_chk.sv
module wbreg_slave_chk (
  input logic        clk,
  input logic        rst,
  input logic        wb_cyc_i,
  input logic        wb_stb_i,
  input logic [31:0] wb_adr_i,
  input logic [31:0] wb_dat_o,
  input logic        wb_ack_o,
  input logic        wb_err_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!wb_ack_o && !wb_err_o && wb_dat_o == 32'h0));

  assert_ack_due_R2: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_i && wb_stb_i && !wb_ack_o && !wb_err_o && wb_adr_i[1:0] == 2'b00)
      |=> wb_ack_o);

  assert_resp_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ((wb_ack_o || wb_err_o) && wb_cyc_i) |=> (wb_ack_o || wb_err_o));

  assert_resp_drop_R3: assert property (@(posedge clk) disable iff (rst)
    !wb_cyc_i |=> (!wb_ack_o && !wb_err_o));

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_ack_o && wb_cyc_i) |=> $stable(wb_dat_o));

  assert_misalign_err_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_i && wb_stb_i && !wb_ack_o && !wb_err_o && wb_adr_i[1:0] != 2'b00)
      |=> (wb_err_o && !wb_ack_o));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!wb_ack_o && !wb_err_o && !(wb_cyc_i && wb_stb_i))
      |=> (!wb_ack_o && !wb_err_o));

  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(wb_ack_o && wb_err_o));
endmodule

bind wbreg_slave wbreg_slave_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wb_cyc_i(wb_cyc_i),
  .wb_stb_i(wb_stb_i),
  .wb_adr_i(wb_adr_i),
  .wb_dat_o(wb_dat_o),
  .wb_ack_o(wb_ack_o),
  .wb_err_o(wb_err_o)
);

// File: tb/test_wbreg_slave.sv
`timescale 1ns/1ps
module test_wbreg_slave;
  localparam int unsigned WIN  = 32;
  localparam int unsigned NREG = 6;

  typedef struct {
    logic        is_err;
    logic        chk_dat;
    logic [31:0] dat;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [31:0] adr = '0, wdat = '0;
  logic [3:0]  sel = '0;
  logic [31:0] rdat;
  logic        ack, err;

  int checks = 0;
  int errors = 0;
  logic        resp_prev = 1'b0;
  logic [31:0] model [NREG];
  exp_t        sb [$];

  always #10 clk = ~clk;

  wbreg_slave #(.WIN_BYTES(WIN), .NUM_REGS(NREG)) i_wbreg_slave (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel),
    .wb_dat_o(rdat), .wb_ack_o(ack), .wb_err_o(err)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // Monitor: compares the first sample of each response with the scoreboard.
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      if ((ack || err) && !resp_prev) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected response", {30'h0, err, ack}, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(err == e.is_err && ack == !e.is_err && !(ack && err),
                {e.tag, " R11 response kind"}, {30'h0, err, ack},
                {30'h0, e.is_err, !e.is_err});
          if (e.chk_dat)
            check(rdat == e.dat, {e.tag, " read data"}, rdat, e.dat);
        end
      end
      resp_prev = ack || err;
    end else begin
      resp_prev = 1'b0;
    end
  end

  // Driver: predicts the result, runs one full cycle, checks timing and hold.
  task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] s, input string tag);
    exp_t        e;
    int unsigned idx;
    idx       = a[4:2];
    e.tag     = tag;
    e.is_err  = (a[1:0] != 2'b00);
    e.chk_dat = 1'b0;
    e.dat     = '0;
    if (!e.is_err) begin
      if (w) begin
        if (idx < NREG)
          for (int l = 0; l < 4; l++)
            if (s[l]) model[idx][8*l +: 8] = d[8*l +: 8];
      end else begin
        e.chk_dat = 1'b1;
        e.dat     = (idx < NREG) ? model[idx] : 32'h0;
      end
    end
    sb.push_back(e);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; sel = s;
    @(posedge clk); #5;
    check((ack || err) == 1'b1, {tag, " R2 response one edge after request"},
          {30'h0, err, ack}, 32'h1);
    @(negedge clk);
    wdat = ~d;  // R4: new data during the hold must not be written
    @(posedge clk); #5;
    check((ack || err) == 1'b1, {tag, " R3 response held while cyc high"},
          {30'h0, err, ack}, 32'h1);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); #5;
    check(!ack && !err, {tag, " R3 response cleared after cyc low"},
          {30'h0, err, ack}, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check(!ack && !err && rdat == 32'h0, "R1 outputs clear in reset",
          rdat | {30'h0, err, ack}, 32'h0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    do_reset();
    // R1: every register reads zero after reset
    for (int i = 0; i < NREG; i++) xfer(1'b0, 32'(4*i), '0, 4'hF, "R1 reset readback");
    // R6: full-word writes and readback
    for (int i = 0; i < NREG; i++)
      xfer(1'b1, 32'(4*i), 32'hA5000000 + 32'(i * 32'h01010101), 4'hF, "R6 write");
    for (int i = 0; i < NREG; i++) xfer(1'b0, 32'(4*i), '0, 4'hF, "R6 read");
    // R5: byte lanes
    xfer(1'b1, 32'h4, 32'hFFFFFFFF, 4'b0001, "R5 lane0");
    xfer(1'b0, 32'h4, '0, 4'hF, "R5 lane0 read");
    xfer(1'b1, 32'h4, 32'h11223344, 4'b1010, "R5 lanes 1,3");
    xfer(1'b0, 32'h4, '0, 4'hF, "R5 lanes 1,3 read");
    xfer(1'b1, 32'h4, 32'h00000000, 4'b0000, "R5 no lanes");
    xfer(1'b0, 32'h4, '0, 4'hF, "R5 no lanes read");
    xfer(1'b1, 32'hC, 32'hDEADBEEF, 4'b0100, "R5 lane2");
    xfer(1'b0, 32'hC, '0, 4'hF, "R5 lane2 read");
    // R7: aliasing above the window
    xfer(1'b1, 32'h4000_0008, 32'hCAFEF00D, 4'hF, "R7 high alias write");
    xfer(1'b0, 32'h0000_0008, '0, 4'hF, "R7 base read");
    xfer(1'b0, 32'hFFFF_FFE8, '0, 4'hF, "R7 top alias read");
    // R8: misaligned accesses give err and change nothing
    xfer(1'b1, 32'h5, 32'h12345678, 4'hF, "R8 misaligned write");
    xfer(1'b1, 32'h13, 32'h0BADF00D, 4'hF, "R8 misaligned write 2");
    xfer(1'b0, 32'h2, '0, 4'hF, "R8 misaligned read");
    xfer(1'b0, 32'h4, '0, 4'hF, "R8 word 1 unchanged");
    xfer(1'b0, 32'h10, '0, 4'hF, "R8 word 4 unchanged");
    // R9: unmapped slots
    xfer(1'b1, 32'h18, 32'h77777777, 4'hF, "R9 unmapped write");
    xfer(1'b0, 32'h18, '0, 4'hF, "R9 unmapped read 0x18");
    xfer(1'b0, 32'h1C, '0, 4'hF, "R9 unmapped read 0x1C");
    xfer(1'b0, 32'h14, '0, 4'hF, "R9 last mapped intact");
    // R10: cyc without stb, and stb without cyc, make no access
    @(negedge clk);
    cyc = 1'b1; stb = 1'b0; we = 1'b1; adr = 32'h0; wdat = 32'h99999999; sel = 4'hF;
    repeat (3) begin
      @(posedge clk); #5;
      check(!ack && !err, "R10 no response with stb low", {30'h0, err, ack}, 32'h0);
    end
    @(negedge clk);
    cyc = 1'b0; stb = 1'b1;
    repeat (2) begin
      @(posedge clk); #5;
      check(!ack && !err, "R10 no response with cyc low", {30'h0, err, ack}, 32'h0);
    end
    @(negedge clk);
    stb = 1'b0; we = 1'b0;
    xfer(1'b0, 32'h0, '0, 4'hF, "R10 word 0 unchanged");
    // R4: the inverted data driven during each hold never landed
    xfer(1'b0, 32'h8, '0, 4'hF, "R4 hold data ignored");
    // R1: reset after use clears the bank
    do_reset();
    for (int i = 0; i < NREG; i++) xfer(1'b0, 32'(4*i), '0, 4'hF, "R1 re-reset readback");
    repeat (3) @(posedge clk);
    #5;
    check(sb.size() == 0, "R2 every expected response seen", 32'(sb.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule